// File: doc/BRIEF.md
# Register Use-Def Access Controller

This block arbitrates the accesses that an in-order pipeline stage makes to a unified register file on behalf of several hardware threads. Each cycle it may take one request, a source read or a destination write, tagged with a thread id and an unsigned sequence number. It decides at once whether the request is done or has to retry. A read is served from the register file when an external dependency tracker says the register is ready. When the register is not ready but a producer can forward, the read is served from the forwarded value instead. A write goes to the file and tells the tracker to drop the front entry for that register.

Ordering is kept per thread with a few registers. One marks the oldest instruction that is blocked on a source operand. Another records the oldest write that is not yet allowed. A third pair holds a barrier flag and a sequence number for an active non-speculative instruction. Younger work from the same thread waits behind these. A squash input drops a same-thread request that is younger than the squash point and resets any ordering register it covers. The block also keeps saturating counters of file reads, forwards and file writes.

Top module: `rua_usedef_ctrl`

## Requirements
- R1: After reset, every ordering register holds the all-ones "none" value, no barrier is active and every counter reads zero, so any request with a sequence number below all-ones can complete.
- R2: While a thread's barrier is active, a request from that thread with a larger sequence number gets retry. Requests from other threads, and requests with a sequence number equal to or smaller than the barrier's, are not affected.
- R3: A request with the non-speculative bit set that is not held by the barrier raises its thread's barrier and records its sequence number. A pulse on `ns_clr_valid` for a thread drops that thread's barrier.
- R4: A read with `dep_can_read` high whose sequence number is not above the thread's blocked-read register completes in the same cycle. It asserts `rf_rd_en` and returns `rf_rd_data` on `rsp_rdata`.
- R5: A read with `dep_can_read` low and `dep_can_fwd` high completes from `dep_fwd_data` when it passes the same ordering check, without asserting `rf_rd_en`. It counts as a forward.
- R6: A read for which neither the file nor the forward path is available gets retry and stores its sequence number in the thread's blocked-read register. Any later read or write from that thread with a larger sequence number then gets retry. The next completed read or forward returns the register to all-ones.
- R7: A write with `dep_can_write` high that passes the ordering check completes. It asserts `rf_wr_en` with `req_wdata`, and it asserts `dep_rm_en` with `dep_rm_reg` equal to the request's register index. A write with `dep_can_write` low gets retry, stores its sequence number in the thread's pending-write register, and asserts neither.
- R8: The 2-bit register class on `rf_sel_class` is 0 (integer) for indices below FP_BASE, with the index passed unchanged. It is 1 (floating point) for indices from FP_BASE up to CTRL_BASE, with FP_BASE subtracted. It is 2 (control) at or above CTRL_BASE, with CTRL_BASE subtracted.
- R9: A squash for a thread resets every ordering register of that thread whose value is at or above the squash number, and keeps smaller values. A same-cycle request from that thread with a larger sequence number is dropped: neither done nor retry, and it has no effect on state or counters.
- R10: The counters of file reads, forwards and file writes increment once per completed access of their kind and saturate at all-ones. `cnt_total` always equals the file reads plus the file writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_tid | input | TID_W | Requesting thread |
| req_seq | input | SEQ_W | Sequence number of the instruction |
| req_is_write | input | 1 | 1 = write destination, 0 = read source |
| req_reg | input | REG_W | Unified register index |
| req_nonspec | input | 1 | Instruction is non-speculative |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | Request completed this cycle |
| rsp_retry | output | 1 | Request refused, retry later |
| rsp_rdata | output | DATA_W | Read result (file or forward) |
| dep_can_read | input | 1 | Tracker: register readable from file |
| dep_can_fwd | input | 1 | Tracker: a producer can forward |
| dep_fwd_data | input | DATA_W | Producer's result |
| dep_can_write | input | 1 | Tracker: destination may be written |
| dep_rm_en | output | 1 | Tracker: remove front entry |
| dep_rm_reg | output | REG_W | Register whose front entry is removed |
| rf_sel_class | output | 2 | Register class of the access |
| rf_sel_idx | output | REG_W | Index within the class |
| rf_rd_en | output | 1 | Register file read strobe |
| rf_rd_data | input | DATA_W | Register file read data |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_data | output | DATA_W | Register file write data |
| ns_clr_valid | input | 1 | Non-speculative instruction graduated |
| ns_clr_tid | input | TID_W | Thread whose barrier clears |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Squashed thread |
| sq_seq | input | SEQ_W | Squash sequence number |
| cnt_rd | output | CNT_W | File read count |
| cnt_fwd | output | CNT_W | Forward count |
| cnt_wr | output | CNT_W | File write count |
| cnt_total | output | CNT_W+1 | File reads plus file writes |

## Verification
The assertions check the following on every cycle: no completion crosses an active barrier or the blocked-read mark, file read and write strobes never coincide, a tracker removal occurs only with a file write, a squashed request is silent, ordering registers fall back to all-ones after a release and after a covering squash, and counters saturate and add up. The bench scenarios show what needs a story of several cycles. A blocked read holds back younger reads and writes while older ones pass, a barrier lifts on graduation, a squash below or above the blocked mark resets it or keeps it, decoded classes appear through the returned data, and counters stop at their limit.

// File: rtl/rua_pkg.sv
package rua_pkg;
   typedef enum logic [1:0] {
      RC_INT  = 2'd0,
      RC_FP   = 2'd1,
      RC_CTRL = 2'd2
   } reg_class_e;
endpackage

// File: rtl/rua_reg_decode.sv
module rua_reg_decode #(
   parameter int REG_W     = 7,
   parameter int FP_BASE   = 32,
   parameter int CTRL_BASE = 64
) (
   input  logic [REG_W-1:0]   reg_idx,
   output rua_pkg::reg_class_e cls,
   output logic [REG_W-1:0]   off
);
   localparam logic [REG_W-1:0] FP_B   = REG_W'(FP_BASE);
   localparam logic [REG_W-1:0] CTRL_B = REG_W'(CTRL_BASE);

   always_comb begin
      if (reg_idx < FP_B) begin
         cls = rua_pkg::RC_INT;
         off = reg_idx;
      end else if (reg_idx < CTRL_B) begin
         cls = rua_pkg::RC_FP;
         off = reg_idx - FP_B;
      end else begin
         cls = rua_pkg::RC_CTRL;
         off = reg_idx - CTRL_B;
      end
   end

   // p_class_range_r8: the offset never exceeds the original index
   always_comb begin
      p_class_range_r8: assert (off <= reg_idx);
   end
endmodule

// File: rtl/rua_thread_state.sv
module rua_thread_state #(
   parameter int SEQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEQ_W-1:0] seq_in,
   input  logic             ns_set,
   input  logic             ns_clr,
   input  logic             rd_hold,
   input  logic             rd_release,
   input  logic             wr_hold,
   input  logic             wr_release,
   input  logic             sq_en,
   input  logic [SEQ_W-1:0] sq_seq,
   output logic             ns_active,
   output logic [SEQ_W-1:0] ns_seq,
   output logic [SEQ_W-1:0] rd_oldest
);
   localparam logic [SEQ_W-1:0] SEQ_NONE = '1;

   logic [SEQ_W-1:0] wr_oldest;
   logic [SEQ_W-1:0] rd_nx, wr_nx;

   always_comb begin
      rd_nx = rd_oldest;
      if (rd_release)   rd_nx = SEQ_NONE;
      else if (rd_hold) rd_nx = seq_in;
      if (sq_en && rd_nx >= sq_seq) rd_nx = SEQ_NONE;

      wr_nx = wr_oldest;
      if (wr_release)   wr_nx = SEQ_NONE;
      else if (wr_hold) wr_nx = seq_in;
      if (sq_en && wr_nx >= sq_seq) wr_nx = SEQ_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_oldest <= SEQ_NONE;
         wr_oldest <= SEQ_NONE;
         ns_active <= 1'b0;
         ns_seq    <= SEQ_NONE;
      end else begin
         rd_oldest <= rd_nx;
         wr_oldest <= wr_nx;
         if (ns_set) begin
            ns_active <= 1'b1;
            ns_seq    <= seq_in;
         end else if (ns_clr) begin
            ns_active <= 1'b0;
         end
      end
   end

   p_rd_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_release |=> rd_oldest == SEQ_NONE);
   p_wr_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_release |=> wr_oldest == SEQ_NONE);
   p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hold && !sq_en) |=> wr_oldest == $past(seq_in));
   p_sq_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sq_en |=> (rd_oldest == SEQ_NONE || rd_oldest < $past(sq_seq)));
   p_sq_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sq_en |=> (wr_oldest == SEQ_NONE || wr_oldest < $past(sq_seq)));
   p_ns_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ns_set |=> (ns_active && ns_seq == $past(seq_in)));
   p_ns_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ns_clr && !ns_set) |=> !ns_active);
endmodule

// File: rtl/rua_sat_counter.sv
module rua_sat_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (inc && count != TOP) count <= count + 1'b1;
   end

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      count == TOP |=> count == TOP);
   p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && count != TOP) |=> count == $past(count) + 1'b1);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));
endmodule

// File: rtl/rua_usedef_ctrl.sv
module rua_usedef_ctrl #(
   parameter int NUM_THREADS = 2,
   parameter int SEQ_W       = 16,
   parameter int REG_W       = 7,
   parameter int DATA_W      = 32,
   parameter int FP_BASE     = 32,
   parameter int CTRL_BASE   = 64,
   parameter int CNT_W       = 32,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [TID_W-1:0]  req_tid,
   input  logic [SEQ_W-1:0]  req_seq,
   input  logic              req_is_write,
   input  logic [REG_W-1:0]  req_reg,
   input  logic              req_nonspec,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic              rsp_retry,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              dep_can_read,
   input  logic              dep_can_fwd,
   input  logic [DATA_W-1:0] dep_fwd_data,
   input  logic              dep_can_write,
   output logic              dep_rm_en,
   output logic [REG_W-1:0]  dep_rm_reg,
   output logic [1:0]        rf_sel_class,
   output logic [REG_W-1:0]  rf_sel_idx,
   output logic              rf_rd_en,
   input  logic [DATA_W-1:0] rf_rd_data,
   output logic              rf_wr_en,
   output logic [DATA_W-1:0] rf_wr_data,
   input  logic              ns_clr_valid,
   input  logic [TID_W-1:0]  ns_clr_tid,
   input  logic              sq_valid,
   input  logic [TID_W-1:0]  sq_tid,
   input  logic [SEQ_W-1:0]  sq_seq,
   output logic [CNT_W-1:0]  cnt_rd,
   output logic [CNT_W-1:0]  cnt_fwd,
   output logic [CNT_W-1:0]  cnt_wr,
   output logic [CNT_W:0]    cnt_total
);
   localparam int NUM_CNT = 3;
   localparam int CI_RD   = 0;
   localparam int CI_FWD  = 1;
   localparam int CI_WR   = 2;

   // elaboration-time parameter checks
   if (NUM_THREADS < 1)                     $error("NUM_THREADS must be at least 1");
   if (SEQ_W < 2)                           $error("SEQ_W must be at least 2");
   if (FP_BASE < 1 || CTRL_BASE <= FP_BASE) $error("need 0 < FP_BASE < CTRL_BASE");
   if (CTRL_BASE >= (1 << REG_W))           $error("CTRL_BASE must fit in REG_W");
   if (CNT_W < 1 || DATA_W < 1)             $error("widths must be positive");

   // per-thread state, flattened for selection by thread id
   logic [NUM_THREADS-1:0] ns_act_v;
   logic [SEQ_W-1:0]       ns_seq_v  [NUM_THREADS];
   logic [SEQ_W-1:0]       rd_old_v  [NUM_THREADS];

   logic             sel_ns_act;
   logic [SEQ_W-1:0] sel_ns_seq, sel_rd_old;

   always_comb begin
      sel_ns_act = 1'b0;
      sel_ns_seq = '1;
      sel_rd_old = '1;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (req_tid == TID_W'(t)) begin
            sel_ns_act = ns_act_v[t];
            sel_ns_seq = ns_seq_v[t];
            sel_rd_old = rd_old_v[t];
         end
      end
   end

   // request classification
   logic dropped, live, barred, passed, in_order;
   logic rd_file, rd_fwd, rd_block, wr_ok, wr_block;

   always_comb begin
      dropped  = req_valid && sq_valid && (sq_tid == req_tid) && (req_seq > sq_seq);
      live     = req_valid && !dropped;
      barred   = sel_ns_act && (req_seq > sel_ns_seq);
      passed   = live && !barred;
      in_order = req_seq <= sel_rd_old;
      rd_file  = passed && !req_is_write && dep_can_read && in_order;
      rd_fwd   = passed && !req_is_write && !dep_can_read && dep_can_fwd && in_order;
      rd_block = passed && !req_is_write && !dep_can_read && !dep_can_fwd;
      wr_ok    = passed && req_is_write && dep_can_write && in_order;
      wr_block = passed && req_is_write && !dep_can_write;
   end

   assign rsp_done  = rd_file || rd_fwd || wr_ok;
   assign rsp_retry = live && !rsp_done;

   always_comb begin
      if (rd_fwd)       rsp_rdata = dep_fwd_data;
      else if (rd_file) rsp_rdata = rf_rd_data;
      else              rsp_rdata = '0;
   end

   // class decode shared by both directions
   rua_pkg::reg_class_e dec_cls;
   logic [REG_W-1:0]    dec_off;

   rua_reg_decode #(
      .REG_W     (REG_W),
      .FP_BASE   (FP_BASE),
      .CTRL_BASE (CTRL_BASE)
   ) u_decode (
      .reg_idx (req_reg),
      .cls     (dec_cls),
      .off     (dec_off)
   );

   assign rf_sel_class = dec_cls;
   assign rf_sel_idx   = dec_off;
   assign rf_rd_en     = rd_file;
   assign rf_wr_en     = wr_ok;
   assign rf_wr_data   = req_wdata;
   assign dep_rm_en    = wr_ok;
   assign dep_rm_reg   = req_reg;

   // one state slice per thread
   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic mine;
      assign mine = (req_tid == TID_W'(t));

      rua_thread_state #(
         .SEQ_W (SEQ_W)
      ) u_state (
         .clk        (clk),
         .rst_n      (rst_n),
         .seq_in     (req_seq),
         .ns_set     (mine && passed && req_nonspec),
         .ns_clr     (ns_clr_valid && ns_clr_tid == TID_W'(t)),
         .rd_hold    (mine && rd_block),
         .rd_release (mine && (rd_file || rd_fwd)),
         .wr_hold    (mine && wr_block),
         .wr_release (mine && wr_ok),
         .sq_en      (sq_valid && sq_tid == TID_W'(t)),
         .sq_seq     (sq_seq),
         .ns_active  (ns_act_v[t]),
         .ns_seq     (ns_seq_v[t]),
         .rd_oldest  (rd_old_v[t])
      );
   end

   // access counters
   logic [NUM_CNT-1:0] cnt_inc;
   logic [CNT_W-1:0]   cnt_val [NUM_CNT];

   assign cnt_inc[CI_RD]  = rd_file;
   assign cnt_inc[CI_FWD] = rd_fwd;
   assign cnt_inc[CI_WR]  = wr_ok;

   for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
      rua_sat_counter #(
         .W (CNT_W)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (cnt_inc[c]),
         .count (cnt_val[c])
      );
   end

   assign cnt_rd    = cnt_val[CI_RD];
   assign cnt_fwd   = cnt_val[CI_FWD];
   assign cnt_wr    = cnt_val[CI_WR];
   assign cnt_total = {1'b0, cnt_rd} + {1'b0, cnt_wr};

   // ordering and port-level checks
   p_barrier_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !(sel_ns_act && req_seq > sel_ns_seq));
   p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_seq <= sel_rd_old);
   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_rd_en && rf_wr_en));
   p_fwd_no_file_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !req_is_write && !dep_can_read) |-> !rf_rd_en);
   p_remove_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dep_rm_en |-> (rf_wr_en && rsp_done && req_is_write));
   p_squash_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && sq_valid && sq_tid == req_tid && req_seq > sq_seq)
         |-> !(rsp_done || rsp_retry || rf_rd_en || rf_wr_en));
   p_total_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_total == CNT_W'(cnt_rd) + (CNT_W+1)'(cnt_wr));
endmodule

// File: tb/rua_usedef_ctrl_tb_top.sv
`timescale 1ns/1ps
module rua_usedef_ctrl_tb_top;
   localparam int NT = 2, SW = 8, RW = 7, DW = 32, CW = 4;
   localparam int TW = 1;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          req_valid = 0, req_is_write = 0, req_nonspec = 0;
   logic [TW-1:0] req_tid = 0;
   logic [SW-1:0] req_seq = 0;
   logic [RW-1:0] req_reg = 0;
   logic [DW-1:0] req_wdata = 0;
   logic          rsp_done, rsp_retry;
   logic [DW-1:0] rsp_rdata;
   logic          dep_can_read = 0, dep_can_fwd = 0, dep_can_write = 0;
   logic [DW-1:0] dep_fwd_data = 0;
   logic          dep_rm_en;
   logic [RW-1:0] dep_rm_reg;
   logic [1:0]    rf_sel_class;
   logic [RW-1:0] rf_sel_idx;
   logic          rf_rd_en, rf_wr_en;
   logic [DW-1:0] rf_rd_data, rf_wr_data;
   logic          ns_clr_valid = 0, sq_valid = 0;
   logic [TW-1:0] ns_clr_tid = 0, sq_tid = 0;
   logic [SW-1:0] sq_seq = 0;
   logic [CW-1:0] cnt_rd, cnt_fwd, cnt_wr;
   logic [CW:0]   cnt_total;

   // register file model: data encodes class and index
   assign rf_rd_data = 32'hC0DE_0000 | (32'(rf_sel_class) << 8) | 32'(rf_sel_idx);

   rua_usedef_ctrl #(.NUM_THREADS(NT), .SEQ_W(SW), .REG_W(RW), .DATA_W(DW),
                     .FP_BASE(32), .CTRL_BASE(64), .CNT_W(CW)) dut_i (
      .clk, .rst_n, .req_valid, .req_tid, .req_seq, .req_is_write, .req_reg,
      .req_nonspec, .req_wdata, .rsp_done, .rsp_retry, .rsp_rdata,
      .dep_can_read, .dep_can_fwd, .dep_fwd_data, .dep_can_write,
      .dep_rm_en, .dep_rm_reg, .rf_sel_class, .rf_sel_idx, .rf_rd_en,
      .rf_rd_data, .rf_wr_en, .rf_wr_data, .ns_clr_valid, .ns_clr_tid,
      .sq_valid, .sq_tid, .sq_seq, .cnt_rd, .cnt_fwd, .cnt_wr, .cnt_total);

   int n_checks = 0, n_fail = 0;
   bit finished = 0;
   int exp_rd = 0, exp_fwd = 0, exp_wr = 0;

   logic g_done, g_retry, g_rd_en, g_wr_en, g_rm;
   logic [DW-1:0] g_rdata, g_wdata;
   logic [1:0]    g_cls;
   logic [RW-1:0] g_idx, g_rm_reg;

   localparam int RES_DROP = 0, RES_DONE = 1, RES_RETRY = 2;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int sat(input int v);
      return (v > 15) ? 15 : v;
   endfunction

   // one request, optionally with a squash in the same cycle
   task automatic acc(input string tag, input logic [TW-1:0] tid, input logic [SW-1:0] seq,
                      input logic wr, input logic [RW-1:0] rg, input logic ns,
                      input logic crd, input logic cfwd, input logic cwr, input int exp_res,
                      input logic sqv = 0, input logic [TW-1:0] sqt = 0,
                      input logic [SW-1:0] sqs = 0);
      @(negedge clk);
      req_valid = 1; req_tid = tid; req_seq = seq; req_is_write = wr; req_reg = rg;
      req_nonspec = ns; req_wdata = 32'hDEAD_0000 | 32'(seq);
      dep_can_read = crd; dep_can_fwd = cfwd; dep_can_write = cwr;
      dep_fwd_data = 32'hF0F0_0000 | 32'(seq);
      sq_valid = sqv; sq_tid = sqt; sq_seq = sqs;
      #2;
      g_done = rsp_done; g_retry = rsp_retry; g_rdata = rsp_rdata; g_rd_en = rf_rd_en;
      g_wr_en = rf_wr_en; g_rm = dep_rm_en; g_rm_reg = dep_rm_reg; g_wdata = rf_wr_data;
      g_cls = rf_sel_class; g_idx = rf_sel_idx;
      chk({tag, " done"}, 32'(g_done), 32'(exp_res == RES_DONE));
      chk({tag, " retry"}, 32'(g_retry), 32'(exp_res == RES_RETRY));
      if (exp_res == RES_DONE) begin
         if (wr)       exp_wr  = sat(exp_wr + 1);
         else if (crd) exp_rd  = sat(exp_rd + 1);
         else          exp_fwd = sat(exp_fwd + 1);
      end
      @(posedge clk); #1;
      req_valid = 0; req_nonspec = 0; sq_valid = 0;
   endtask

   task automatic squash_only(input logic [TW-1:0] t, input logic [SW-1:0] s);
      @(negedge clk); sq_valid = 1; sq_tid = t; sq_seq = s;
      @(posedge clk); #1; sq_valid = 0;
   endtask

   task automatic ns_clear(input logic [TW-1:0] t);
      @(negedge clk); ns_clr_valid = 1; ns_clr_tid = t;
      @(posedge clk); #1; ns_clr_valid = 0;
   endtask

   task automatic check_counters(input string tag);
      chk({tag, " R10 cnt_rd"}, 32'(cnt_rd), 32'(exp_rd));
      chk({tag, " R10 cnt_fwd"}, 32'(cnt_fwd), 32'(exp_fwd));
      chk({tag, " R10 cnt_wr"}, 32'(cnt_wr), 32'(exp_wr));
      chk({tag, " R10 cnt_total"}, 32'(cnt_total), 32'(exp_rd + exp_wr));
   endtask

   task automatic t_reset;
      #1;
      chk("R1 idle done", 32'(rsp_done), 0);
      chk("R1 idle retry", 32'(rsp_retry), 0);
      check_counters("R1");
      acc("R1 seq FE", 0, 8'hFE, 0, 3, 0, 1, 0, 0, RES_DONE);
      chk("R1 rdata", g_rdata, 32'hC0DE_0003);
   endtask

   task automatic t_read_decode;
      acc("R4 int", 0, 5, 0, 3, 0, 1, 0, 0, RES_DONE);
      chk("R4 rf_rd_en", 32'(g_rd_en), 1);
      chk("R8 int data", g_rdata, 32'hC0DE_0003);
      acc("R8 fp", 0, 5, 0, 40, 0, 1, 0, 0, RES_DONE);
      chk("R8 fp data", g_rdata, 32'hC0DE_0108);
      acc("R8 fp low edge", 1, 5, 0, 32, 0, 1, 0, 0, RES_DONE);
      chk("R8 fp edge", g_rdata, 32'hC0DE_0100);
      acc("R8 ctrl", 0, 5, 0, 70, 0, 1, 0, 0, RES_DONE);
      chk("R8 ctrl data", g_rdata, 32'hC0DE_0206);
      acc("R8 int high edge", 0, 5, 0, 31, 0, 1, 0, 0, RES_DONE);
      chk("R8 int edge", g_rdata, 32'hC0DE_001F);
      check_counters("R4");
   endtask

   task automatic t_forward;
      acc("R5 fwd", 0, 6, 0, 4, 0, 0, 1, 0, RES_DONE);
      chk("R5 fwd data", g_rdata, 32'hF0F0_0006);
      chk("R5 no rf_rd_en", 32'(g_rd_en), 0);
      check_counters("R5");
   endtask

   task automatic t_order;
      acc("R6 block", 0, 10, 0, 5, 0, 0, 0, 0, RES_RETRY);
      acc("R6 younger read", 0, 12, 0, 5, 0, 1, 0, 0, RES_RETRY);
      chk("R6 no rd_en", 32'(g_rd_en), 0);
      acc("R6 younger fwd", 0, 12, 0, 5, 0, 0, 1, 0, RES_RETRY);
      acc("R7 younger write", 0, 12, 1, 5, 0, 0, 0, 1, RES_RETRY);
      chk("R7 no wr_en", 32'(g_wr_en), 0);
      acc("R6 other thread", 1, 50, 0, 5, 0, 1, 0, 0, RES_DONE);
      acc("R6 equal seq", 0, 10, 0, 5, 0, 1, 0, 0, RES_DONE);
      acc("R6 released", 0, 12, 0, 5, 0, 1, 0, 0, RES_DONE);
      check_counters("R6");
   endtask

   task automatic t_write;
      acc("R7 write", 0, 20, 1, 35, 0, 0, 0, 1, RES_DONE);
      chk("R7 wr_en", 32'(g_wr_en), 1);
      chk("R7 wr data", g_wdata, 32'hDEAD_0014);
      chk("R7 rm_en", 32'(g_rm), 1);
      chk("R7 rm reg", 32'(g_rm_reg), 35);
      chk("R8 wr class", 32'(g_cls), 1);
      chk("R8 wr idx", 32'(g_idx), 3);
      acc("R7 write blocked", 0, 21, 1, 35, 0, 0, 0, 0, RES_RETRY);
      chk("R7 blocked wr_en", 32'(g_wr_en), 0);
      chk("R7 blocked rm", 32'(g_rm), 0);
      check_counters("R7");
   endtask

   task automatic t_barrier;
      acc("R3 ns read", 0, 30, 0, 2, 1, 1, 0, 0, RES_DONE);
      acc("R2 younger", 0, 31, 0, 2, 0, 1, 0, 0, RES_RETRY);
      acc("R2 younger write", 0, 32, 1, 2, 0, 0, 0, 1, RES_RETRY);
      acc("R2 older", 0, 28, 0, 2, 0, 1, 0, 0, RES_DONE);
      acc("R2 equal", 0, 30, 0, 2, 0, 1, 0, 0, RES_DONE);
      acc("R2 other thread", 1, 90, 0, 2, 0, 1, 0, 0, RES_DONE);
      ns_clear(0);
      acc("R3 cleared", 0, 31, 0, 2, 0, 1, 0, 0, RES_DONE);
      check_counters("R3");
   endtask

   task automatic t_squash;
      acc("R9 block 40", 0, 40, 0, 6, 0, 0, 0, 0, RES_RETRY);
      squash_only(0, 45);
      acc("R9 kept below", 0, 42, 0, 6, 0, 1, 0, 0, RES_RETRY);
      squash_only(1, 10);
      acc("R9 other thread squash", 0, 42, 0, 6, 0, 1, 0, 0, RES_RETRY);
      squash_only(0, 35);
      acc("R9 reset above", 0, 42, 0, 6, 0, 1, 0, 0, RES_DONE);
      acc("R9 drop", 0, 55, 0, 6, 0, 1, 0, 0, RES_DROP, 1, 0, 50);
      chk("R9 drop rd_en", 32'(g_rd_en), 0);
      check_counters("R9 after drop");
      acc("R9 drop write", 0, 56, 1, 6, 0, 0, 0, 1, RES_DROP, 1, 0, 50);
      chk("R9 drop wr_en", 32'(g_wr_en), 0);
      acc("R9 not younger", 0, 48, 0, 6, 0, 1, 0, 0, RES_DONE, 1, 0, 50);
      acc("R9 other tid", 0, 60, 0, 6, 0, 1, 0, 0, RES_DONE, 1, 1, 10);
      check_counters("R9");
   endtask

   task automatic t_saturate;
      for (int i = 0; i < 6; i++)
         acc("R10 fill", 1, 8'(100 + i), 0, 1, 0, 1, 0, 0, RES_DONE);
      chk("R10 sat value", 32'(cnt_rd), 15);
      check_counters("R10 sat");
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #200_000_0;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_read_decode();
      t_forward();
      t_order();
      t_write();
      t_barrier();
      t_squash();
      t_saturate();
      report();
   end
endmodule